// File: doc/BRIEF.md
# Processor Bus Address Decoder with Keypad Matrix Read

This block sits between an 8-bit processor and the devices on its 16-bit address bus. From the address alone it raises one chip select among work RAM, two four-register peripheral windows, a tile-code RAM, a tile-attribute RAM and program ROM. For the two windows it also gives out the register index within the window. Decoding is purely combinational, so the selects follow the address in the same cycle.

The block also holds two local resources of its own. The first is a write-only selector register at `0x0850` that chooses which of four keypad switch groups is visible. The second is a read port at `0x0851` for a four-bit DIP switch bank. The read-data mux returns one of three things: the data of whichever device is selected, the local keypad or DIP value, or `0xFF` for an address that decodes to nothing.

Top module: `bus_decoder_top`

## Requirements
- R1: Addresses 0x0000 to 0x07FF raise `cs_wram` and no other select.
- R2: Addresses 0x0844 to 0x0847 raise `cs_per0`, and 0x0848 to 0x084B raise `cs_per1`. In both windows `per_reg` equals address bits 1:0.
- R3: Addresses 0x1000 to 0x13FF raise `cs_tcode`, and 0x1800 to 0x1BFF raise `cs_tattr`.
- R4: Addresses 0xC000 to 0xFFFF raise `cs_rom`.
- R5: At most one select is high at any time. Every address outside the ranges of R1 to R4 raises no select. A read from any address that is neither such a range nor 0x0850 or 0x0851 returns 0xFF.
- R6: A write (`cpu_we` high at a clock edge) to 0x0850 stores the bitwise inverse of `cpu_wdata` in the selector register. Reset clears the register to 0x00, so no group is selected. Writes to any other address leave the register unchanged.
- R7: A read at 0x0850 returns keypad group k (`key_sw[8k+7:8k]`, active low) when the stored register's bits 7:4 equal the one-hot value 1<<k, for k from 0 to 3.
- R8: A read at 0x0850 returns 0xFF when the stored bits 7:4 are zero or have more than one bit set.
- R9: A read at 0x0851 returns `{dip_sw[3:0], 4'hF}`. Only bits 7:4 are connected and bits 3:0 always read as 1.
- R10: While any chip select is high, `cpu_rdata` equals `ext_rdata`.
- R11: A read at 0x0850 in the same cycle as a selector write reflects the register value from before that write. The new group appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | Write strobe, sampled at the rising edge |
| cpu_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the selected external device |
| key_sw | input | 32 | Four active-low switch groups, group k in bits 8k+7:8k |
| dip_sw | input | 4 | DIP switches, read back on data bits 7:4 |
| cpu_rdata | output | 8 | Read data to the processor |
| cs_wram | output | 1 | Work RAM select |
| cs_per0 | output | 1 | First peripheral window select |
| cs_per1 | output | 1 | Second peripheral window select |
| per_reg | output | 2 | Register index within a peripheral window |
| cs_tcode | output | 1 | Tile-code RAM select |
| cs_tattr | output | 1 | Tile-attribute RAM select |
| cs_rom | output | 1 | Program ROM select |

## Verification
The selector write and the keypad read share address 0x0850, so they can fall in the same cycle. The read is combinational, while the register only takes the new value at the clock edge. The bench provokes this by holding `cpu_we` high at 0x0850 across a clock edge with a new group encoded in the data. It then samples `cpu_rdata` before that edge, where the old group is expected, and again after it, where the new group is expected. Writes to neighbouring addresses are checked separately for not disturbing the register.

// File: rtl/busdec_pkg.sv
`timescale 1ns/1ps
package busdec_pkg;

    typedef enum logic [3:0] {
        RGN_NONE  = 4'd0,
        RGN_WRAM  = 4'd1,
        RGN_PER0  = 4'd2,
        RGN_PER1  = 4'd3,
        RGN_TCODE = 4'd4,
        RGN_TATTR = 4'd5,
        RGN_ROM   = 4'd6,
        RGN_KEYS  = 4'd7,
        RGN_DIP   = 4'd8
    } region_e;

    typedef struct packed {
        logic wram;
        logic per0;
        logic per1;
        logic tcode;
        logic tattr;
        logic rom;
    } cs_t;

    localparam logic [15:0] WRAM_LO  = 16'h0000, WRAM_HI  = 16'h07FF;
    localparam logic [15:0] PER0_LO  = 16'h0844, PER0_HI  = 16'h0847;
    localparam logic [15:0] PER1_LO  = 16'h0848, PER1_HI  = 16'h084B;
    localparam logic [15:0] TCODE_LO = 16'h1000, TCODE_HI = 16'h13FF;
    localparam logic [15:0] TATTR_LO = 16'h1800, TATTR_HI = 16'h1BFF;
    localparam logic [15:0] ROM_LO   = 16'hC000, ROM_HI   = 16'hFFFF;

    function automatic logic in_span(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic region_e classify(input logic [15:0] a,
                                         input logic [15:0] keys_at,
                                         input logic [15:0] dip_at);
        region_e r;
        r = RGN_NONE;
        if      (in_span(a, WRAM_LO,  WRAM_HI))  r = RGN_WRAM;
        else if (in_span(a, PER0_LO,  PER0_HI))  r = RGN_PER0;
        else if (in_span(a, PER1_LO,  PER1_HI))  r = RGN_PER1;
        else if (in_span(a, TCODE_LO, TCODE_HI)) r = RGN_TCODE;
        else if (in_span(a, TATTR_LO, TATTR_HI)) r = RGN_TATTR;
        else if (in_span(a, ROM_LO,   ROM_HI))   r = RGN_ROM;
        else if (a == keys_at)                   r = RGN_KEYS;
        else if (a == dip_at)                    r = RGN_DIP;
        return r;
    endfunction

endpackage

// File: rtl/bd_addr_decode.sv
`timescale 1ns/1ps
module bd_addr_decode
    import busdec_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] KEYS_AT  = 16'h0850,
    parameter logic [15:0] DIP_AT   = 16'h0851
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output cs_t               cs,
    output logic [1:0]        win_reg
);
    always_comb begin
        rgn = classify(addr, KEYS_AT, DIP_AT);
        cs  = '0;
        unique case (rgn)
            RGN_WRAM:  cs.wram  = 1'b1;
            RGN_PER0:  cs.per0  = 1'b1;
            RGN_PER1:  cs.per1  = 1'b1;
            RGN_TCODE: cs.tcode = 1'b1;
            RGN_TATTR: cs.tattr = 1'b1;
            RGN_ROM:   cs.rom   = 1'b1;
            default:   cs       = '0;
        endcase
        win_reg = addr[1:0];
    end
endmodule

// File: rtl/bd_sel_latch.sv
`timescale 1ns/1ps
module bd_sel_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= ~wdata;
    end
endmodule

// File: rtl/bd_key_mux.sv
`timescale 1ns/1ps
module bd_key_mux #(
    parameter int DATA_W = 8,
    parameter int GROUPS = 4
) (
    input  logic [DATA_W-1:0]        sel,
    input  logic [GROUPS*DATA_W-1:0] keys,
    output logic [DATA_W-1:0]        data
);
    localparam int FIELD_LSB = DATA_W - GROUPS;

    logic [GROUPS-1:0] field;
    logic [GROUPS-1:0] hit;
    logic [DATA_W-1:0] picked [GROUPS];

    assign field = sel[DATA_W-1:FIELD_LSB];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign hit[g]    = (field == (GROUPS'(1) << g));
        assign picked[g] = hit[g] ? keys[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        data = '0;
        for (int g = 0; g < GROUPS; g++)
            data = data | picked[g];
        if (hit == '0)
            data = '1;
    end
endmodule

// File: rtl/bus_decoder_top.sv
`timescale 1ns/1ps
module bus_decoder_top
    import busdec_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int          GROUPS  = 4,
    parameter logic [15:0] KEYS_AT = 16'h0850,
    parameter logic [15:0] DIP_AT  = 16'h0851
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_we,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic [DATA_W-1:0]        ext_rdata,
    input  logic [GROUPS*DATA_W-1:0] key_sw,
    input  logic [DATA_W/2-1:0]      dip_sw,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cs_wram,
    output logic                     cs_per0,
    output logic                     cs_per1,
    output logic [1:0]               per_reg,
    output logic                     cs_tcode,
    output logic                     cs_tattr,
    output logic                     cs_rom
);
    localparam int HALF = DATA_W / 2;

    region_e           rgn;
    cs_t               cs;
    logic [DATA_W-1:0] sel_q;
    logic [DATA_W-1:0] key_data;
    logic              sel_wr;

    bd_addr_decode #(.ADDR_W(ADDR_W), .KEYS_AT(KEYS_AT), .DIP_AT(DIP_AT)) u_dec (
        .addr    (cpu_addr),
        .rgn     (rgn),
        .cs      (cs),
        .win_reg (per_reg)
    );

    assign sel_wr = cpu_we && (rgn == RGN_KEYS);

    bd_sel_latch #(.DATA_W(DATA_W)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .wr    (sel_wr),
        .wdata (cpu_wdata),
        .q     (sel_q)
    );

    bd_key_mux #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_keys (
        .sel  (sel_q),
        .keys (key_sw),
        .data (key_data)
    );

    assign cs_wram  = cs.wram;
    assign cs_per0  = cs.per0;
    assign cs_per1  = cs.per1;
    assign cs_tcode = cs.tcode;
    assign cs_tattr = cs.tattr;
    assign cs_rom   = cs.rom;

    always_comb begin
        unique case (rgn)
            RGN_KEYS: cpu_rdata = key_data;
            RGN_DIP:  cpu_rdata = {dip_sw, {HALF{1'b1}}};
            RGN_NONE: cpu_rdata = '1;
            default:  cpu_rdata = ext_rdata;
        endcase
    end
endmodule

// File: rtl/bd_checker.sv
`timescale 1ns/1ps
module bd_checker #(
    parameter logic [15:0] KEYS_AT = 16'h0850,
    parameter logic [15:0] DIP_AT  = 16'h0851
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_we,
    input logic [7:0]  cpu_wdata,
    input logic [7:0]  ext_rdata,
    input logic [7:0]  cpu_rdata,
    input logic [7:0]  sel_q,
    input logic [5:0]  cs_vec
);
    p_single_cs_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_vec));

    p_wram_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr < 16'h0800) |-> (cs_vec == 6'b100000));

    p_rom_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b11) |-> (cs_vec == 6'b000001));

    p_sel_store_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == KEYS_AT) |=> (sel_q == ~$past(cpu_wdata)));

    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && cpu_addr == KEYS_AT) |=> $stable(sel_q));

    p_dip_low_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == DIP_AT) |-> (cpu_rdata[3:0] == 4'hF));

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        (cs_vec != 6'b0) |-> (cpu_rdata == ext_rdata));

    p_idle_ff_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_vec == 6'b0 && cpu_addr != KEYS_AT && cpu_addr != DIP_AT)
            |-> (cpu_rdata == 8'hFF));
endmodule

bind bus_decoder_top bd_checker #(.KEYS_AT(KEYS_AT), .DIP_AT(DIP_AT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .ext_rdata (ext_rdata),
    .cpu_rdata (cpu_rdata),
    .sel_q     (sel_q),
    .cs_vec    ({cs_wram, cs_per0, cs_per1, cs_tcode, cs_tattr, cs_rom})
);

// File: tb/tb_bus_decoder_top.sv
`timescale 1ns/1ps
module tb_bus_decoder_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr  = 16'h2000;
    logic        cpu_we    = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  ext_rdata = 8'h5A;
    logic [31:0] key_sw    = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
    logic [3:0]  dip_sw    = 4'b1010;
    logic [7:0]  cpu_rdata;
    logic        cs_wram, cs_per0, cs_per1, cs_tcode, cs_tattr, cs_rom;
    logic [1:0]  per_reg;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [15:0] KEYS = 16'h0850;
    localparam logic [15:0] DIP  = 16'h0851;

    always #2 clk = ~clk;

    bus_decoder_top dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .ext_rdata(ext_rdata), .key_sw(key_sw),
        .dip_sw(dip_sw), .cpu_rdata(cpu_rdata), .cs_wram(cs_wram),
        .cs_per0(cs_per0), .cs_per1(cs_per1), .per_reg(per_reg),
        .cs_tcode(cs_tcode), .cs_tattr(cs_tattr), .cs_rom(cs_rom)
    );

    function automatic logic [7:0] grp(input int k);
        return key_sw[k*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_we   = 1'b0;
        #1 d = cpu_rdata;
    endtask

    task automatic write_at(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = v;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [5:0] exp_cs, input string tag);
        @(negedge clk);
        cpu_addr = a;
        #1 chk(tag, {cs_wram, cs_per0, cs_per1, cs_tcode, cs_tattr, cs_rom}, exp_cs);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        read_at(KEYS, d);
        chk("R6 reset selects no group", d, 8'hFF);
    endtask

    task automatic t_ranges;
        probe(16'h0000, 6'b100000, "R1 wram low");
        probe(16'h07FF, 6'b100000, "R1 wram high");
        probe(16'h0800, 6'b000000, "R5 above wram");
        probe(16'h0843, 6'b000000, "R5 below per0");
        probe(16'h0844, 6'b010000, "R2 per0 low");
        chk("R2 per_reg 0", per_reg, 2'd0);
        probe(16'h0847, 6'b010000, "R2 per0 high");
        chk("R2 per_reg 3", per_reg, 2'd3);
        probe(16'h0848, 6'b001000, "R2 per1 low");
        probe(16'h084A, 6'b001000, "R2 per1 mid");
        chk("R2 per_reg 2", per_reg, 2'd2);
        probe(16'h084B, 6'b001000, "R2 per1 high");
        probe(16'h084C, 6'b000000, "R5 above per1");
        probe(16'h1000, 6'b000100, "R3 tcode low");
        probe(16'h13FF, 6'b000100, "R3 tcode high");
        probe(16'h1400, 6'b000000, "R5 tile gap");
        probe(16'h1800, 6'b000010, "R3 tattr low");
        probe(16'h1BFF, 6'b000010, "R3 tattr high");
        probe(16'h1C00, 6'b000000, "R5 above tattr");
        probe(16'hBFFF, 6'b000000, "R5 below rom");
        probe(16'hC000, 6'b000001, "R4 rom low");
        probe(16'hFFFF, 6'b000001, "R4 rom high");
        probe(KEYS,     6'b000000, "R5 keys no cs");
    endtask

    task automatic t_readmux;
        logic [7:0] d;
        ext_rdata = 8'h5A;
        read_at(16'h2000, d);   chk("R5 unmapped read", d, 8'hFF);
        read_at(16'h0852, d);   chk("R5 unmapped near keys", d, 8'hFF);
        read_at(16'h0845, d);   chk("R10 per0 passthru", d, 8'h5A);
        ext_rdata = 8'h3C;
        read_at(16'hC123, d);   chk("R10 rom passthru", d, 8'h3C);
        read_at(16'h1805, d);   chk("R10 tattr passthru", d, 8'h3C);
    endtask

    task automatic t_groups;
        logic [7:0] d;
        logic [7:0] wv [4] = '{8'hEF, 8'hDF, 8'hBF, 8'h7F};
        for (int k = 0; k < 4; k++) begin
            write_at(KEYS, wv[k]);
            read_at(KEYS, d);
            chk($sformatf("R7 group %0d", k), d, grp(k));
        end
        write_at(KEYS, 8'hE0);  // lower bits differ, still group 0
        read_at(KEYS, d);       chk("R7 group 0 lower bits ignored", d, grp(0));
        key_sw[7:0] = 8'h0F;
        read_at(KEYS, d);       chk("R7 live switch change", d, 8'h0F);
        key_sw[7:0] = 8'hA1;
    endtask

    task automatic t_bad_nibbles;
        logic [7:0] d;
        write_at(KEYS, 8'hCF);  read_at(KEYS, d); chk("R8 two bits", d, 8'hFF);
        write_at(KEYS, 8'hFF);  read_at(KEYS, d); chk("R8 zero nibble", d, 8'hFF);
        write_at(KEYS, 8'h0F);  read_at(KEYS, d); chk("R8 all bits", d, 8'hFF);
    endtask

    task automatic t_dip;
        logic [7:0] d;
        dip_sw = 4'b1010;
        read_at(DIP, d);  chk("R9 dip a", d, 8'hAF);
        dip_sw = 4'b0001;
        read_at(DIP, d);  chk("R9 dip b", d, 8'h1F);
    endtask

    task automatic t_stray_writes;
        logic [7:0] d;
        write_at(KEYS, 8'hDF);
        write_at(16'h0852, 8'hEF);
        write_at(16'h0000, 8'hEF);
        write_at(DIP, 8'hEF);
        write_at(16'h0844, 8'hEF);
        read_at(KEYS, d);
        chk("R6 other writes ignored", d, grp(1));
    endtask

    task automatic t_collision;
        logic [7:0] d;
        write_at(KEYS, 8'hEF);
        @(negedge clk);
        cpu_addr  = KEYS;
        cpu_wdata = 8'hBF;
        cpu_we    = 1'b1;
        #1 chk("R11 old group during write", cpu_rdata, grp(0));
        @(negedge clk);
        cpu_we = 1'b0;
        #1 chk("R11 new group after write", cpu_rdata, grp(2));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ranges();
        t_readmux();
        t_groups();
        t_bad_nibbles();
        t_dip();
        t_stray_writes();
        t_collision();
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule